// File: doc/BRIEF.md
# Digital DC Offset Canceller

This block removes a slowly varying DC offset from a stream of 12-bit samples. Every clock it subtracts a correction value from the incoming sample and registers the result. The correction comes from a leaky first-order loop. Each cycle the loop adds the difference between the corrected sample and a target level to a wide signed accumulator. The applied correction is that accumulator shifted right by a power of two. Over time the corrected stream averages to mid-code plus a small signed pedestal.

The loop time constant is chosen by a 4-bit code. It doubles at each step, from 2^BASE_SHIFT cycles up to 2^(BASE_SHIFT+11) cycles. The default base of 20 gives about one million to two billion cycles. A freeze input stops the estimate from changing while the held correction is still applied. When the loop is not enabled, or when a bypass input is active, samples pass through unchanged and the accumulator is cleared.

Top module: `offset_trim_loop`

## Requirements
- R1: While `rstN` is low, `sampleOut` is 0 and the accumulator is empty.
- R2: When `enable` is low or `bypass` is high, `sampleOut` equals the `sampleIn` of the previous cycle, and the accumulator is cleared to zero.
- R3: When `enable` is high and `bypass` is low, each sample is corrected every cycle. `sampleOut` equals the previous cycle's `sampleIn` minus the correction in force in that cycle, with one register of latency.
- R4: For a constant input with pedestal 0, the corrected output settles exactly at mid-code 2048, whether the offset is positive or negative.
- R5: `pedestal` is a 4-bit two's complement value from -8 to +7. It is added to the settling target, so the output settles at 2048 + pedestal.
- R6: A time-constant code k in 0..11 sets the correction to the accumulator arithmetically shifted right by BASE_SHIFT + k. Each increment of k doubles the loop time constant.
- R7: Codes 12 through 15 are reserved and behave exactly like code 11.
- R8: While `freeze` is high and the loop is active, the accumulator holds its value. The last correction keeps being subtracted from every sample.
- R9: The corrected sample saturates at 0 and 4095 instead of wrapping.
- R10: After the loop is disabled and then enabled again, the first corrected sample uses zero correction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Turns the correction loop on |
| freeze | input | 1 | Holds the current offset estimate |
| bypass | input | 1 | Low-latency bypass: passes samples through and clears the loop |
| tcCode | input | 4 | Time-constant code; 0..11 valid, 12..15 act as 11 |
| pedestal | input | 4 | Signed offset added to the settling target |
| sampleIn | input | 12 | Unsigned input sample |
| sampleOut | output | 12 | Corrected, registered sample |

## Verification
Two functions can act on the same sample in the same cycle: the held correction under freeze, and output saturation. The bench provokes this by first letting the loop settle on a constant input at a rail, so the correction is about half of full scale. It then freezes the loop and drives the opposite rail. The sample then has a frozen correction subtracted that pushes it past the range. The output is judged correct only if it is exactly 4095 or 0 and does not move while the freeze is held. A second overlap is disable followed by enable. Here the bench checks that the clear and the first corrected sample meet on one edge with zero correction.

// File: rtl/offset_trim_pkg.sv
package offset_trim_pkg;

  // Strobes from the control decoder to the datapath.
  typedef struct packed {
    logic correctOn;   // subtract the correction from the sample
    logic accumulate;  // integrate the error this cycle
    logic clearAcc;    // empty the accumulator
  } trim_strobe_t;

  // Highest time-constant code that has a distinct meaning.
  localparam int TC_CODE_LAST = 11;

endpackage

// File: rtl/offset_trim_ctrl.sv
module offset_trim_ctrl
  import offset_trim_pkg::*;
#(
  parameter int BASE_SHIFT = 20,
  parameter int TC_W       = 4,
  parameter int SHIFT_W    = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               freeze,
  input  logic               bypass,
  input  logic [TC_W-1:0]    tcCode,
  output trim_strobe_t       strobes,
  output logic [SHIFT_W-1:0] shiftAmt
);

  localparam logic [TC_W-1:0] CODE_CAP = TC_W'(TC_CODE_LAST);

  logic [TC_W-1:0] effCode;
  logic            loopLive;

  // Reserved codes fold onto the slowest valid setting.
  always_comb begin
    effCode = (tcCode > CODE_CAP) ? CODE_CAP : tcCode;
  end

  always_comb begin
    loopLive           = enable & ~bypass;
    strobes.correctOn  = loopLive;
    strobes.accumulate = loopLive & ~freeze;
    strobes.clearAcc   = ~loopLive;
  end

  always_comb begin
    shiftAmt = SHIFT_W'(BASE_SHIFT) + SHIFT_W'(effCode);
  end

  // R7: the shift never exceeds the slowest valid setting.
  assert_shift_cap_R7: assert property (@(posedge clk) disable iff (!rstN)
    shiftAmt <= SHIFT_W'(BASE_SHIFT + TC_CODE_LAST));

  // R8: a frozen live loop never integrates.
  assert_freeze_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (freeze && strobes.correctOn) |-> !strobes.accumulate);

endmodule

// File: rtl/offset_trim_datapath.sv
module offset_trim_datapath
  import offset_trim_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int PED_W    = 4,
  parameter int SHIFT_W  = 6,
  parameter int ACC_W    = 45
) (
  input  logic                clk,
  input  logic                rstN,
  input  trim_strobe_t        strobes,
  input  logic [SHIFT_W-1:0]  shiftAmt,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic [PED_W-1:0]    pedestal,
  output logic [SAMPLE_W-1:0] sampleOut
);

  localparam int CORR_W  = SAMPLE_W + 2;
  localparam int DIFF_W  = CORR_W + 1;
  localparam int ERR_W   = SAMPLE_W + 2;
  localparam int FULL    = (1 << SAMPLE_W) - 1;
  localparam int MID     = 1 << (SAMPLE_W - 1);
  localparam int CORR_LIM = 1 << SAMPLE_W;

  localparam logic signed [ACC_W-1:0]  CORR_HI = ACC_W'(CORR_LIM);
  localparam logic signed [ACC_W-1:0]  CORR_LO = -CORR_HI;
  localparam logic signed [ACC_W-1:0]  ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0]  ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [DIFF_W-1:0] DIFF_FULL = DIFF_W'(FULL);
  localparam logic signed [ERR_W-1:0]  MID_CODE  = ERR_W'(MID);

  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  accShifted;
  logic signed [CORR_W-1:0] corr;
  logic signed [DIFF_W-1:0] diff;
  logic [SAMPLE_W-1:0]      corrected;
  logic signed [ERR_W-1:0]  target;
  logic signed [ERR_W-1:0]  err;
  logic signed [ACC_W:0]    accSum;
  logic signed [ACC_W-1:0]  accNext;
  logic [SAMPLE_W-1:0]      outNext;

  // Correction: accumulator scaled by the time constant, kept in range.
  always_comb begin
    accShifted = acc >>> shiftAmt;
    if (accShifted > CORR_HI)      corr = CORR_W'(CORR_LIM);
    else if (accShifted < CORR_LO) corr = -CORR_W'(CORR_LIM);
    else                           corr = accShifted[CORR_W-1:0];
  end

  // Subtract and clamp to the sample range.
  always_comb begin
    diff = signed'({{(DIFF_W-SAMPLE_W){1'b0}}, sampleIn}) - {corr[CORR_W-1], corr};
    if (diff < 0)              corrected = '0;
    else if (diff > DIFF_FULL) corrected = SAMPLE_W'(FULL);
    else                       corrected = diff[SAMPLE_W-1:0];
  end

  // Error against mid-code plus the signed pedestal.
  always_comb begin
    target = MID_CODE + {{(ERR_W-PED_W){pedestal[PED_W-1]}}, pedestal};
    err    = signed'({{(ERR_W-SAMPLE_W){1'b0}}, corrected}) - target;
  end

  // Integrate with saturation so the accumulator cannot wrap.
  always_comb begin
    accSum = {acc[ACC_W-1], acc} + {{(ACC_W+1-ERR_W){err[ERR_W-1]}}, err};
    if (accSum[ACC_W] != accSum[ACC_W-1])
      accNext = accSum[ACC_W] ? ACC_MIN : ACC_MAX;
    else
      accNext = accSum[ACC_W-1:0];
  end

  always_comb begin
    outNext = strobes.correctOn ? corrected : sampleIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      sampleOut <= '0;
    end else begin
      sampleOut <= outNext;
      if (strobes.clearAcc)        acc <= '0;
      else if (strobes.accumulate) acc <= accNext;
    end
  end

  // R2: an inactive loop leaves the accumulator empty.
  assert_clear_when_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAcc |=> (acc == '0));

  // R2: an inactive loop passes samples through with one cycle of delay.
  assert_pass_through_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.correctOn |=> (sampleOut == $past(sampleIn)));

  // R8: the estimate holds while frozen.
  assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.correctOn && !strobes.accumulate) |=> (acc == $past(acc)));

  // R10: the first sample after a restart carries no correction.
  assert_restart_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.correctOn && acc == '0) |=> (sampleOut == $past(sampleIn)));

endmodule

// File: rtl/offset_trim_loop.sv
module offset_trim_loop
  import offset_trim_pkg::*;
#(
  parameter int SAMPLE_W   = 12,
  parameter int PED_W      = 4,
  parameter int TC_W       = 4,
  parameter int BASE_SHIFT = 20
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                freeze,
  input  logic                bypass,
  input  logic [TC_W-1:0]     tcCode,
  input  logic [PED_W-1:0]    pedestal,
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0] sampleOut
);

  localparam int MAX_SHIFT = BASE_SHIFT + TC_CODE_LAST;
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);
  localparam int ACC_W     = MAX_SHIFT + SAMPLE_W + 2;

  trim_strobe_t       strobes;
  logic [SHIFT_W-1:0] shiftAmt;

  offset_trim_ctrl #(
    .BASE_SHIFT (BASE_SHIFT),
    .TC_W       (TC_W),
    .SHIFT_W    (SHIFT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .freeze   (freeze),
    .bypass   (bypass),
    .tcCode   (tcCode),
    .strobes  (strobes),
    .shiftAmt (shiftAmt)
  );

  offset_trim_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .PED_W    (PED_W),
    .SHIFT_W  (SHIFT_W),
    .ACC_W    (ACC_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .shiftAmt  (shiftAmt),
    .sampleIn  (sampleIn),
    .pedestal  (pedestal),
    .sampleOut (sampleOut)
  );

endmodule

// File: tb/offset_trim_loop_bench.sv
`timescale 1ns/1ps
module offset_trim_loop_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        enable, freeze, bypass;
  logic [3:0]  tcCode, pedestal;
  logic [11:0] sampleIn;
  logic [11:0] sampleOut;

  int testsRun  = 0;
  int testsFail = 0;

  always #2.5 clk = ~clk;

  // Small base shift keeps every loop time constant short in the bench.
  offset_trim_loop #(.BASE_SHIFT(2)) u_offset_trim_loop (
    .clk(clk), .rstN(rstN), .enable(enable), .freeze(freeze), .bypass(bypass),
    .tcCode(tcCode), .pedestal(pedestal), .sampleIn(sampleIn), .sampleOut(sampleOut)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart();
    enable = 1'b0; freeze = 1'b0; bypass = 1'b0;
    tick(2);
  endtask

  task automatic test_reset();
    sampleIn = 12'd1234;
    tick(2);
    check("R1 reset output", sampleOut, 0);
    rstN = 1'b1;
  endtask

  task automatic test_passthrough();
    restart();
    sampleIn = 12'd1500; tick();
    check("R2 disabled pass", sampleOut, 1500);
    sampleIn = 12'd77; tick();
    check("R2 disabled pass", sampleOut, 77);
    enable = 1'b1; bypass = 1'b1; sampleIn = 12'd2100; tick(20);
    check("R2 bypass pass", sampleOut, 2100);
    bypass = 1'b0;
  endtask

  task automatic test_converge();
    restart();
    tcCode = 4'd0; pedestal = 4'd0;
    enable = 1'b1; sampleIn = 12'd2058; tick(300);
    check("R4 positive offset", sampleOut, 2048);
    restart();
    enable = 1'b1; sampleIn = 12'd2028; tick(300);
    check("R4 negative offset", sampleOut, 2048);
  endtask

  task automatic test_pedestal();
    restart();
    tcCode = 4'd0; pedestal = 4'd5;
    enable = 1'b1; sampleIn = 12'd2058; tick(300);
    check("R5 pedestal +5", sampleOut, 2053);
    restart();
    pedestal = 4'b1000;
    enable = 1'b1; tick(300);
    check("R5 pedestal -8", sampleOut, 2040);
    pedestal = 4'd0;
  endtask

  task automatic test_step();
    restart();
    tcCode = 4'd0; enable = 1'b1; sampleIn = 12'd2112; tick();
    check("R10 first sample uncorrected", sampleOut, 2112);
    tick();
    check("R6 code 0 step", sampleOut, 2096);
    restart();
    tcCode = 4'd2; enable = 1'b1; tick();
    check("R3 first sample", sampleOut, 2112);
    tick();
    check("R6 code 2 step", sampleOut, 2108);
  endtask

  task automatic test_reserved();
    restart();
    tcCode = 4'd12; enable = 1'b1; sampleIn = 12'd2112; tick(140);
    check("R7 code 12 as 11", sampleOut, 2111);
    restart();
    tcCode = 4'd15; enable = 1'b1; tick(140);
    check("R7 code 15 as 11", sampleOut, 2111);
    tcCode = 4'd0;
  endtask

  task automatic test_freeze();
    restart();
    enable = 1'b1; sampleIn = 12'd2058; tick(300);
    check("R8 settle before freeze", sampleOut, 2048);
    freeze = 1'b1; sampleIn = 12'd2100; tick(50);
    check("R8 frozen correction", sampleOut, 2090);
    tick(50);
    check("R8 still frozen", sampleOut, 2090);
    freeze = 1'b0; tick(300);
    check("R8 resumes after thaw", sampleOut, 2048);
  endtask

  task automatic test_saturate();
    restart();
    enable = 1'b1; sampleIn = 12'd0; tick(400);
    check("R9 settle from low rail", sampleOut, 2048);
    freeze = 1'b1; sampleIn = 12'd4095; tick(2);
    check("R9 clamp high", sampleOut, 4095);
    restart();
    enable = 1'b1; sampleIn = 12'd4095; tick(400);
    check("R9 settle from high rail", sampleOut, 2048);
    freeze = 1'b1; sampleIn = 12'd0; tick(2);
    check("R9 clamp low", sampleOut, 0);
    sampleIn = 12'd100; tick(2);
    check("R9 clamp low small", sampleOut, 0);
  endtask

  initial begin
    rstN = 1'b0; enable = 1'b0; freeze = 1'b0; bypass = 1'b0;
    tcCode = 4'd0; pedestal = 4'd0; sampleIn = 12'd0;
    test_reset();
    test_passthrough();
    test_converge();
    test_pedestal();
    test_step();
    test_reserved();
    test_freeze();
    test_saturate();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    #1000000;
    testsRun++;
    testsFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule